// File: doc/BRIEF.md
# Command Ring Buffer Fetcher

The block reads 32-bit command words out of a circular command buffer held in memory and hands them, strictly in order, to a downstream packet decoder over a valid/ready word stream. The host programs the buffer base address and a power-of-two ring size, then moves a write index forward. Whenever the internal read index differs from the write index, the block fetches the words between them. The read index wraps through a mask, so a write index that has wrapped past the ring end needs no special handling. When the block is done, the read index equals the write index.

A decoder that meets a call into a secondary, linear command list can ask the block to fetch that list instead. It supplies a start address and a word count. The block fetches exactly that many words from consecutive addresses with no wrap, marks them as secondary on the stream, and then resumes the ring at the index where it stopped. Every fetch address keeps bits 28:0 of the computed address and takes bits 31:29 from the ring base. The block also keeps the largest write index the host has ever written.

The memory port carries one read at a time. The request is held with its address until it is accepted, and the single response is expected with `mem_rsp_valid`. On the output stream, `out_data` and `out_from_ib` stay stable while `out_valid` is high and `out_ready` is low. The block fetches nothing new until the held word is taken, so back-pressure stalls the whole pipeline.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After a synchronous reset, `rptr_out` and `wptr_max_out` are 0, the stored write index is 0, and `mem_req_valid` and `out_valid` are low.
- R2: While the read index equals the write index (masked to the ring size) and no secondary fetch is pending, no memory request is issued.
- R3: After a write index is written, the block emits the words at read indices rptr, rptr+1, … up to but not including the write index, in that order, with `out_from_ib` = 0. `rptr_out` then equals the write index.
- R4: The ring holds 2^F words, where F is the size field clamped to MAX_LOG2. A primary fetch reads address base + ((index AND (2^F−1)) × 4), so indices wrap modulo 2^F.
- R5: Every fetch address, primary or secondary, has bits 31:29 equal to bits 31:29 of the ring base and bits 28:0 equal to those of the computed address.
- R6: A secondary request with length L > 0, accepted while no secondary fetch is active, yields exactly L words from start + i×4 (i = 0…L−1) with no wrap and `out_from_ib` = 1. These words come out contiguously, and the ring then continues from the same read index. Secondary words do not move `rptr_out`.
- R7: A secondary request that arrives while a secondary fetch is active raises `ib_err` for one cycle, one clock after the request, and is otherwise ignored. A request with length 0 produces no words and no error.
- R8: `wptr_max_out` is the largest write index written since reset and never decreases.
- R9: Only one memory read is outstanding at a time. The address and `mem_req_valid` are held until accepted, and the output word is held stable while `out_ready` is low.
- R10: A write to the size field clears the read index and the write index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base_we | input | 1 | Load ring base address |
| cfg_base_in | input | 32 | Ring base byte address |
| cfg_size_we | input | 1 | Load ring size field (also clears indices) |
| cfg_size_in | input | SZ_W | log2 of ring size in words |
| wptr_we | input | 1 | Load write index |
| wptr_in | input | MAX_LOG2 | Write index in words |
| rptr_out | output | MAX_LOG2 | Current read index |
| wptr_max_out | output | MAX_LOG2 | Largest write index written |
| ib_req | input | 1 | Secondary list fetch request |
| ib_addr | input | 32 | Secondary list start byte address |
| ib_len | input | LEN_W | Secondary list length in words |
| ib_err | output | 1 | One-cycle pulse: request rejected as nested |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Command word valid |
| out_ready | input | 1 | Decoder accepts word |
| out_data | output | 32 | Command word |
| out_from_ib | output | 1 | Word comes from a secondary list |

## Verification
The ring function is swept over every advance distance from 1 to 2^F−1 for several ring sizes, including a size field above the maximum. Because the advances accumulate, the write index lands below the read index many times, which separates correct masked wrap from tail-segment or unmasked arithmetic. The memory returns each word's own address as its data, so every output word shows the exact address that was fetched. A ring base just below a bit-29 boundary exposes both carry into the upper bits and the upper-bit substitution. Secondary lists are tried from idle, injected in the middle of a primary run, nested, and with zero length. The interleaved case shows that the secondary words are contiguous and that ring order survives the detour. The memory and output stall patterns rotate from run to run, so back-pressure cannot reorder, drop or duplicate a word.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_OUT  = 2'd3
  } fetch_state_t;

  localparam logic [31:0] HI_KEEP_MASK = 32'hE000_0000;

  // upper three address bits come from the ring base
  function automatic logic [31:0] remap_hi(input logic [31:0] ring_base,
                                           input logic [31:0] raw);
    return (raw & ~HI_KEEP_MASK) | (ring_base & HI_KEEP_MASK);
  endfunction

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs #(
  parameter int MAX_LOG2 = 10,
  parameter int SZ_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_base_we,
  input  logic [31:0]         cfg_base_in,
  input  logic                cfg_size_we,
  input  logic [SZ_W-1:0]     cfg_size_in,
  input  logic                wptr_we,
  input  logic [MAX_LOG2-1:0] wptr_in,
  output logic [31:0]         base_q,
  output logic [MAX_LOG2-1:0] mask_q,
  output logic [MAX_LOG2-1:0] wptr_q,
  output logic [MAX_LOG2-1:0] wptr_max_q
);

  logic [SZ_W-1:0]   eff_log2;
  logic [MAX_LOG2:0] one_w;
  logic [MAX_LOG2:0] span_m1;

  always_comb begin
    eff_log2 = (cfg_size_in > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : cfg_size_in;
    one_w    = {{MAX_LOG2{1'b0}}, 1'b1};
    span_m1  = (one_w << eff_log2) - one_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      mask_q     <= '0;
      wptr_q     <= '0;
      wptr_max_q <= '0;
    end else begin
      if (cfg_base_we) base_q <= cfg_base_in;
      if (cfg_size_we) begin
        mask_q <= span_m1[MAX_LOG2-1:0];
        wptr_q <= '0;
      end else if (wptr_we) begin
        wptr_q <= wptr_in;
      end
      if (wptr_we && (wptr_in > wptr_max_q)) wptr_max_q <= wptr_in;
    end
  end

  // R8
  wmax_mono_chk: assert property (@(posedge clk) disable iff (rst)
    wptr_max_q >= $past(wptr_max_q));

  // R8
  wmax_cover_chk: assert property (@(posedge clk) disable iff (rst)
    wptr_we |=> (wptr_max_q >= $past(wptr_in)));

endmodule

// File: rtl/cmd_ring_addr.sv
module cmd_ring_addr #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 16
) (
  input  logic [31:0]      ring_base,
  input  logic [IDX_W-1:0] rptr,
  input  logic [31:0]      ib_start,
  input  logic [LEN_W-1:0] ib_off,
  input  logic             sel_ib,
  output logic [31:0]      fetch_addr
);
  import cmd_ring_pkg::*;

  logic [31:0] origin;
  logic [31:0] byte_off;
  logic [31:0] raw_sum;

  always_comb begin
    if (sel_ib) begin
      origin   = ib_start;
      byte_off = {{(30-LEN_W){1'b0}}, ib_off, 2'b00};
    end else begin
      origin   = ring_base;
      byte_off = {{(30-IDX_W){1'b0}}, rptr, 2'b00};
    end
    raw_sum    = origin + byte_off;
    fetch_addr = remap_hi(ring_base, raw_sum);
  end

endmodule

// File: rtl/cmd_ring_seq.sv
module cmd_ring_seq #(
  parameter int IDX_W = 10,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] mask,
  input  logic [IDX_W-1:0] wptr,
  input  logic             ring_clear,
  input  logic             ib_req,
  input  logic [31:0]      ib_addr,
  input  logic [LEN_W-1:0] ib_len,
  output logic             ib_err,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_from_ib,
  output logic [IDX_W-1:0] rptr,
  output logic [31:0]      ib_start,
  output logic [LEN_W-1:0] ib_off,
  output logic             sel_ib
);
  import cmd_ring_pkg::*;

  fetch_state_t     state_q;
  logic [IDX_W-1:0] rptr_q;
  logic [LEN_W-1:0] ib_left_q;
  logic [LEN_W-1:0] ib_off_q;
  logic [31:0]      ib_start_q;
  logic             cur_ib_q;
  logic [31:0]      data_q;
  logic             err_q;
  logic             ib_busy;
  logic             ring_pending;

  always_comb begin
    ib_busy      = (ib_left_q != '0);
    ring_pending = (rptr_q != (wptr & mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      rptr_q     <= '0;
      ib_left_q  <= '0;
      ib_off_q   <= '0;
      ib_start_q <= '0;
      cur_ib_q   <= 1'b0;
      data_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= ib_req && ib_busy;
      if (ib_req && !ib_busy && (ib_len != '0)) begin
        ib_start_q <= ib_addr;
        ib_left_q  <= ib_len;
        ib_off_q   <= '0;
      end
      unique case (state_q)
        FS_IDLE: begin
          if (ib_busy) begin
            cur_ib_q <= 1'b1;
            state_q  <= FS_REQ;
          end else if (ring_pending) begin
            cur_ib_q <= 1'b0;
            state_q  <= FS_REQ;
          end
        end
        FS_REQ: begin
          if (mem_req_ready) state_q <= FS_WAIT;
        end
        FS_WAIT: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_data;
            state_q <= FS_OUT;
          end
        end
        FS_OUT: begin
          if (out_ready) begin
            if (cur_ib_q) begin
              ib_off_q  <= ib_off_q + 1'b1;
              ib_left_q <= ib_left_q - 1'b1;
            end else begin
              rptr_q <= (rptr_q + 1'b1) & mask;
            end
            state_q <= FS_IDLE;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
      if (ring_clear) rptr_q <= '0;
    end
  end

  always_comb begin
    mem_req_valid = (state_q == FS_REQ);
    out_valid     = (state_q == FS_OUT);
    out_data      = data_q;
    out_from_ib   = cur_ib_q;
    ib_err        = err_q;
    rptr          = rptr_q;
    ib_start      = ib_start_q;
    ib_off        = ib_off_q;
    sel_ib        = cur_ib_q;
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_from_ib)));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  // R9
  one_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && out_valid));

  // R3
  rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rptr_q != $past(rptr_q)) |->
      ((rptr_q == ($past(rptr_q + 1'b1) & $past(mask))) || (rptr_q == '0)));

  // R6
  ib_keeps_rptr_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_from_ib && !ring_clear) |=> $stable(rptr_q));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ib_err |-> $past(ib_req));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_IDLE && !ring_pending && !ib_busy) |=> !mem_req_valid);

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int MAX_LOG2 = 10,
  parameter int LEN_W    = 16,
  localparam int SZ_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_base_we,
  input  logic [31:0]         cfg_base_in,
  input  logic                cfg_size_we,
  input  logic [SZ_W-1:0]     cfg_size_in,
  input  logic                wptr_we,
  input  logic [MAX_LOG2-1:0] wptr_in,
  output logic [MAX_LOG2-1:0] rptr_out,
  output logic [MAX_LOG2-1:0] wptr_max_out,
  input  logic                ib_req,
  input  logic [31:0]         ib_addr,
  input  logic [LEN_W-1:0]    ib_len,
  output logic                ib_err,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [31:0]         mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_data,
  output logic                out_from_ib
);

  logic [31:0]         base_q;
  logic [MAX_LOG2-1:0] mask_q;
  logic [MAX_LOG2-1:0] wptr_q;
  logic [MAX_LOG2-1:0] rptr_w;
  logic [31:0]         ib_start_w;
  logic [LEN_W-1:0]    ib_off_w;
  logic                sel_ib_w;

  cmd_ring_regs #(.MAX_LOG2(MAX_LOG2), .SZ_W(SZ_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cfg_base_we (cfg_base_we),
    .cfg_base_in (cfg_base_in),
    .cfg_size_we (cfg_size_we),
    .cfg_size_in (cfg_size_in),
    .wptr_we     (wptr_we),
    .wptr_in     (wptr_in),
    .base_q      (base_q),
    .mask_q      (mask_q),
    .wptr_q      (wptr_q),
    .wptr_max_q  (wptr_max_out)
  );

  cmd_ring_seq #(.IDX_W(MAX_LOG2), .LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .mask          (mask_q),
    .wptr          (wptr_q),
    .ring_clear    (cfg_size_we),
    .ib_req        (ib_req),
    .ib_addr       (ib_addr),
    .ib_len        (ib_len),
    .ib_err        (ib_err),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_from_ib   (out_from_ib),
    .rptr          (rptr_w),
    .ib_start      (ib_start_w),
    .ib_off        (ib_off_w),
    .sel_ib        (sel_ib_w)
  );

  cmd_ring_addr #(.IDX_W(MAX_LOG2), .LEN_W(LEN_W)) u_addr (
    .ring_base  (base_q),
    .rptr       (rptr_w),
    .ib_start   (ib_start_w),
    .ib_off     (ib_off_w),
    .sel_ib     (sel_ib_w),
    .fetch_addr (mem_req_addr)
  );

  assign rptr_out = rptr_w;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  // R5
  hi_bits_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[31:29] == base_q[31:29]));

endmodule

// File: tb/tb_cmd_ring_fetch.sv
module tb_cmd_ring_fetch;
  localparam int ML = 4;
  localparam int LW = 8;
  localparam int SW = $clog2(ML + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_base_we, cfg_size_we, wptr_we;
  logic [31:0]   cfg_base_in;
  logic [SW-1:0] cfg_size_in;
  logic [ML-1:0] wptr_in, rptr_out, wptr_max_out;
  logic          ib_req, ib_err;
  logic [31:0]   ib_addr;
  logic [LW-1:0] ib_len;
  logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0]   mem_req_addr, mem_rsp_data;
  logic          out_valid, out_ready, out_from_ib;
  logic [31:0]   out_data;

  always #5 clk = ~clk;

  cmd_ring_fetch #(.MAX_LOG2(ML), .LEN_W(LW)) dut (
    .clk(clk), .rst(rst),
    .cfg_base_we(cfg_base_we), .cfg_base_in(cfg_base_in),
    .cfg_size_we(cfg_size_we), .cfg_size_in(cfg_size_in),
    .wptr_we(wptr_we), .wptr_in(wptr_in),
    .rptr_out(rptr_out), .wptr_max_out(wptr_max_out),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len), .ib_err(ib_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_from_ib(out_from_ib)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int req_cnt = 0;
  int n_got = 0;
  int stall_mode = 0;
  bit pending = 0;
  logic [31:0] pend_a;
  logic [31:0] got_d [0:511];
  logic        got_i [0:511];
  logic [31:0] base_v;
  int mask_v;
  int rp;
  int maxw;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] remap(input logic [31:0] raw);
    return {base_v[31:29], raw[28:0]};
  endfunction

  // memory model (data = address) and stream sink
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    out_ready     = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pending) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_a;
        pending       = 0;
      end
      case (stall_mode)
        0: begin mem_req_ready = 1'b1; out_ready = 1'b1; end
        1: begin mem_req_ready = (cyc % 2 == 0); out_ready = (cyc % 3 != 0); end
        default: begin mem_req_ready = (cyc % 3 != 1); out_ready = (cyc % 2 == 1); end
      endcase
      if (mem_req_valid && mem_req_ready) begin
        pending = 1;
        pend_a  = mem_req_addr;
        req_cnt++;
      end
      if (out_valid && out_ready) begin
        if (n_got < 512) begin
          got_d[n_got] = out_data;
          got_i[n_got] = out_from_ib;
        end
        n_got++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic drain();
    int q = 0;
    while (q < 8) begin
      @(negedge clk); #1;
      if (!out_valid && !mem_req_valid && !pending && !mem_rsp_valid) q++;
      else q = 0;
    end
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(negedge clk); #1; cfg_base_we = 1'b1; cfg_base_in = v;
    @(negedge clk); #1; cfg_base_we = 1'b0;
    base_v = v;
  endtask

  task automatic wr_size(input int f);
    @(negedge clk); #1; cfg_size_we = 1'b1; cfg_size_in = SW'(f);
    @(negedge clk); #1; cfg_size_we = 1'b0;
    mask_v = (1 << ((f > ML) ? ML : f)) - 1;
    rp = 0;
  endtask

  task automatic wr_wptr(input int v);
    @(negedge clk); #1; wptr_we = 1'b1; wptr_in = ML'(v);
    @(negedge clk); #1; wptr_we = 1'b0;
    if (v > maxw) maxw = v;
  endtask

  task automatic pulse_ib(input logic [31:0] a, input int len);
    @(negedge clk); #1; ib_req = 1'b1; ib_addr = a; ib_len = LW'(len);
    @(negedge clk); #1; ib_req = 1'b0;
  endtask

  // R3 R4 R5: advance the write index by k and check every word
  task automatic ring_step(input int k);
    int wp;
    wp = (rp + k) & mask_v;
    stall_mode = k % 3;
    n_got = 0;
    wr_wptr(wp);
    drain();
    chk(n_got == k, "R3 word count", n_got, k);
    for (int i = 0; i < k && i < 512; i++) begin
      chk(got_d[i] == remap(base_v + 32'(((rp + i) & mask_v) * 4)),
          "R4 R5 ring word address", got_d[i], remap(base_v + 32'(((rp + i) & mask_v) * 4)));
      chk(got_i[i] == 1'b0, "R3 primary flag", got_i[i], 0);
    end
    chk(rptr_out == ML'(wp), "R3 read index ends at write index", rptr_out, wp);
    rp = wp;
  endtask

  initial begin
    int snap;
    int first_ib;
    int n_ib;
    int n_pr;
    int wp;
    rst = 1'b1;
    cfg_base_we = 0; cfg_size_we = 0; wptr_we = 0;
    cfg_base_in = '0; cfg_size_in = '0; wptr_in = '0;
    ib_req = 0; ib_addr = '0; ib_len = '0;
    base_v = '0; mask_v = 0; rp = 0; maxw = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(rptr_out == 0, "R1 reset rptr", rptr_out, 0);
    chk(wptr_max_out == 0, "R1 reset wptr_max", wptr_max_out, 0);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(mem_req_valid == 0, "R1 reset mem_req_valid", mem_req_valid, 0);
    rst = 1'b0;

    // R2: equal indices -> no traffic
    wr_wptr(0);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R2 idle with equal indices", req_cnt, 0);

    wr_base(32'h3FFF_FFF0);

    // R10 and sweeps over ring sizes 4, 8, 16 words
    for (int f = 2; f <= 4; f++) begin
      wr_wptr(3);
      drain();
      wr_size(f);
      chk(rptr_out == 0, "R10 size write clears read index", rptr_out, 0);
      snap = req_cnt;
      repeat (12) @(negedge clk);
      chk(req_cnt == snap, "R10 size write clears write index", req_cnt - snap, 0);
      for (int k = 1; k <= mask_v; k++) ring_step(k);
      ring_step(mask_v);
    end

    // R4 clamp: field 7 behaves as 16 words
    wr_size(7);
    ring_step(10);
    ring_step(8);
    ring_step(15);

    // R8
    chk(wptr_max_out == ML'(maxw), "R8 max write index", wptr_max_out, maxw);
    wr_wptr((rp + 1) & mask_v);
    rp = (rp + 1) & mask_v;
    drain();
    chk(wptr_max_out == ML'(maxw), "R8 max after smaller write", wptr_max_out, maxw);

    // R2: write index equal to read index again
    snap = req_cnt;
    wr_wptr(rp);
    repeat (20) @(negedge clk);
    chk(req_cnt == snap, "R2 no fetch when equal", req_cnt - snap, 0);

    // R6 from idle, crossing bit 29
    stall_mode = 1;
    n_got = 0;
    pulse_ib(32'h1FFF_FFF8, 5);
    drain();
    chk(n_got == 5, "R6 idle list length", n_got, 5);
    for (int i = 0; i < 5; i++) begin
      chk(got_d[i] == remap(32'h1FFF_FFF8 + 32'(i * 4)), "R6 R5 list address",
          got_d[i], remap(32'h1FFF_FFF8 + 32'(i * 4)));
      chk(got_i[i] == 1'b1, "R6 list flag", got_i[i], 1);
    end
    chk(rptr_out == ML'(rp), "R6 list keeps read index", rptr_out, rp);

    // R6 injected into a primary run
    stall_mode = 2;
    n_got = 0;
    wp = (rp + 12) & mask_v;
    wr_wptr(wp);
    while (n_got < 2) @(negedge clk);
    #1;
    pulse_ib(32'h0000_1000, 4);
    drain();
    n_ib = 0; n_pr = 0; first_ib = -1;
    for (int i = 0; i < n_got && i < 512; i++) begin
      if (got_i[i]) begin
        if (first_ib < 0) first_ib = i;
        chk(got_d[i] == remap(32'h0000_1000 + 32'(n_ib * 4)), "R6 injected list address",
            got_d[i], remap(32'h0000_1000 + 32'(n_ib * 4)));
        n_ib++;
      end else begin
        chk(got_d[i] == remap(base_v + 32'(((rp + n_pr) & mask_v) * 4)),
            "R6 ring order around list", got_d[i],
            remap(base_v + 32'(((rp + n_pr) & mask_v) * 4)));
        n_pr++;
      end
    end
    chk(n_ib == 4, "R6 injected list length", n_ib, 4);
    chk(n_pr == 12, "R6 ring words around list", n_pr, 12);
    chk(first_ib >= 0 && got_i[first_ib + 3] && got_i[first_ib + 1] && got_i[first_ib + 2],
        "R6 list contiguous", first_ib, 0);
    chk(rptr_out == ML'(wp), "R6 ring resumes to end", rptr_out, wp);
    rp = wp;

    // R7 nested request
    stall_mode = 0;
    n_got = 0;
    @(negedge clk); #1; ib_req = 1'b1; ib_addr = 32'h1FFF_FFF8; ib_len = LW'(6);
    @(negedge clk); #1;
    chk(ib_err == 1'b0, "R7 no error on first request", ib_err, 0);
    ib_addr = 32'h0ABC_0000; ib_len = LW'(3);
    @(negedge clk); #1; ib_req = 1'b0;
    chk(ib_err == 1'b1, "R7 error on nested request", ib_err, 1);
    @(negedge clk); #1;
    chk(ib_err == 1'b0, "R7 error is one cycle", ib_err, 0);
    drain();
    chk(n_got == 6, "R7 nested request ignored", n_got, 6);
    for (int i = 0; i < 6; i++)
      chk(got_d[i] == remap(32'h1FFF_FFF8 + 32'(i * 4)), "R7 first list kept",
          got_d[i], remap(32'h1FFF_FFF8 + 32'(i * 4)));

    // R7 zero-length request
    n_got = 0;
    @(negedge clk); #1; ib_req = 1'b1; ib_addr = 32'h0000_2000; ib_len = '0;
    @(negedge clk); #1; ib_req = 1'b0;
    @(negedge clk); #1;
    chk(ib_err == 1'b0, "R7 zero length no error", ib_err, 0);
    drain();
    chk(n_got == 0, "R7 zero length no words", n_got, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule